// File: doc/BRIEF.md
# Fan Speed PWM Generator with Timed Spin-Up

This block generates the speed-command waveform for a four-wire cooling fan from the system clock. The carrier period is a fixed number of clocks. With the default of 2000 clocks at 50 MHz, the carrier runs at 25 kHz. The speed request is a percentage from 0 to 100. It is mapped to a compare count and kept inside a minimum-to-full window. The pin is driven in open-drain style: `pwm_oe` pulls the line to the constant low level on `pwm_lo`, and otherwise an external pull-up holds the line high.

A stalled fan may not start at a low duty. For that reason, each start is preceded by a spin-up phase at full duty. A start is an enable rising edge, or a nonzero request that follows a zero "stop" request. The length of the spin-up phase is given in whole carrier periods. For the default carrier, 5000 to 12500 periods covers 200 ms to 500 ms. After the spin-up phase the output settles on the clamped request. A polarity input selects whether the active phase of the waveform is the high level or the low level on the pin. The idle level, used when disabled or stopped, is always the opposite of the active level.

Speed requests arrive on a valid/ready channel that holds one entry. A request is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until the accepted value has been applied. This happens at the next carrier period boundary, or on the next clock while the block is disabled. A sender must hold `cmd_valid` and `cmd_duty` steady until the request is accepted. A request that is presented while `cmd_ready` is low is not lost.

Top module: `fan_pwm_kick`

## Requirements
- R1: The carrier period is exactly PERIOD clocks. In a running period, the active level is present for floor(d*PERIOD/100) clocks, where d is the clamped request. These are the first clocks of the period.
- R2: After a start, the output stays active for the whole period for `kick_len` consecutive periods, and `kick_active` is high during exactly those periods. The period that follows uses the clamped request.
- R3: A start while `kick_len` is 0 skips the spin-up phase, so the first period already uses the clamped request.
- R4: A nonzero request below 20 is raised to 20, and a request above 100 is lowered to 100.
- R5: A request of 0 with `en` high stops the fan. From the next period boundary on, every clock of the period is at the idle level and `kick_active` is low. The next nonzero request starts a new spin-up phase.
- R6: An accepted request changes the waveform only from the next period boundary on. The period in progress keeps its old compare count.
- R7: `cmd_ready` is high when no request is pending. After an acceptance it falls on the following clock and stays low until the period boundary that applies the value. A request held during that time is accepted afterwards and applied one period later.
- R8: `pwm_lo` is always 0, and the pin level is low exactly when `pwm_oe` is 1. With `pol` 0 the active level is high (idle low, `pwm_oe`=1 when idle). With `pol` 1 the active level is low (idle high, `pwm_oe`=0 when idle).
- R9: On the clock after `en` is sampled low, the pin is at the idle level and `kick_active` is low. A later enable with a nonzero request starts a spin-up phase again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces the idle level |
| pol | input | 1 | 0: active high / idle low; 1: active low / idle high |
| kick_len | input | KW | Spin-up length in carrier periods (0 disables spin-up) |
| cmd_valid | input | 1 | Speed request valid |
| cmd_ready | output | 1 | Request slot free |
| cmd_duty | input | DW | Requested duty in percent |
| pwm_oe | output | 1 | Pull-down enable for the open-drain pin |
| pwm_lo | output | 1 | Level driven while `pwm_oe` is 1, always 0 |
| kick_active | output | 1 | High while the spin-up phase runs |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. They check that the pin is at the full active level whenever the spin-up flag is high. They check that the spin-up flag is only raised while the block is enabled. They check that a spin-up never lasts longer than `kick_len` periods. They check that the pin falls to idle one clock after disable, and that the request slot closes after each acceptance. Other behaviour only shows up in the scenarios: the per-period active counts, floor and ceiling clamping, the one-period delay before a new request takes effect, and a new spin-up after a stop or a re-enable. These are measured by counting the active clocks in each period at the pin and comparing them against a scoreboard.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

  typedef enum logic [1:0] {
    FS_OFF  = 2'd0,
    FS_STOP = 2'd1,
    FS_KICK = 2'd2,
    FS_RUN  = 2'd3
  } fan_state_t;

  localparam int PCT_FULL = 100;

endpackage

// File: rtl/fan_pwm_carrier.sv
module fan_pwm_carrier #(
  parameter int PERIOD = 2000,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  // Parked on the last count while disabled, so the first enabled edge
  // opens a fresh period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= LAST;
    end else if (!en) begin
      cnt <= LAST;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign wrap = en && (cnt == LAST);

endmodule

// File: rtl/fan_pwm_duty_map.sv
module fan_pwm_duty_map #(
  parameter int PERIOD  = 2000,
  parameter int DW      = 7,
  parameter int MIN_PCT = 20,
  localparam int MCW = $clog2(PERIOD + 1)
) (
  input  logic [DW-1:0]  duty_pct,
  output logic [MCW-1:0] cmp
);

  import fan_pwm_pkg::*;

  localparam logic [DW-1:0] FLOOR_PCT = DW'(MIN_PCT);
  localparam logic [DW-1:0] TOP_PCT   = DW'(PCT_FULL);
  localparam int PW = DW + MCW + 1;

  logic [DW-1:0] clamped;

  always_comb begin
    if (duty_pct == '0) begin
      clamped = '0;
    end else if (duty_pct < FLOOR_PCT) begin
      clamped = FLOOR_PCT;
    end else if (duty_pct > TOP_PCT) begin
      clamped = TOP_PCT;
    end else begin
      clamped = duty_pct;
    end
  end

  generate
    if (PERIOD % PCT_FULL == 0) begin : g_exact
      // Period is a whole multiple of 100: a constant multiply suffices.
      localparam int STEP = PERIOD / PCT_FULL;
      logic [PW-1:0] prod;
      assign prod = PW'(clamped) * PW'(STEP);
      assign cmp  = MCW'(prod);
    end else begin : g_div
      logic [PW-1:0] prod;
      logic [PW-1:0] quot;
      assign prod = PW'(clamped) * PW'(PERIOD);
      assign quot = prod / PW'(PCT_FULL);
      assign cmp  = MCW'(quot);
    end
  endgenerate

endmodule

// File: rtl/fan_pwm_kick_seq.sv
module fan_pwm_kick_seq #(
  parameter int PERIOD = 2000,
  parameter int KW     = 14,
  localparam int MCW = $clog2(PERIOD + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           wrap,
  input  logic           req_zero,
  input  logic [MCW-1:0] run_cmp,
  input  logic [KW-1:0]  kick_len,
  output logic [MCW-1:0] cmp_q,
  output logic           kicking
);

  import fan_pwm_pkg::*;

  localparam logic [MCW-1:0] CMP_FULL = MCW'(PERIOD);

  fan_state_t     state;
  logic [KW-1:0]  left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FS_OFF;
      cmp_q <= '0;
      left  <= '0;
    end else if (!en) begin
      state <= FS_OFF;
      cmp_q <= '0;
      left  <= '0;
    end else if (wrap) begin
      if (req_zero) begin
        state <= FS_STOP;
        cmp_q <= '0;
        left  <= '0;
      end else begin
        case (state)
          FS_OFF, FS_STOP: begin
            if (kick_len == '0) begin
              state <= FS_RUN;
              cmp_q <= run_cmp;
            end else begin
              state <= FS_KICK;
              cmp_q <= CMP_FULL;
              left  <= kick_len - KW'(1);
            end
          end
          FS_KICK: begin
            if (left == '0) begin
              state <= FS_RUN;
              cmp_q <= run_cmp;
            end else begin
              left  <= left - KW'(1);
              cmp_q <= CMP_FULL;
            end
          end
          default: begin
            state <= FS_RUN;
            cmp_q <= run_cmp;
          end
        endcase
      end
    end
  end

  assign kicking = (state == FS_KICK);

endmodule

// File: rtl/fan_pwm_kick.sv
module fan_pwm_kick #(
  parameter int PERIOD  = 2000,
  parameter int DW      = 7,
  parameter int KW      = 14,
  parameter int MIN_PCT = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pol,
  input  logic [KW-1:0] kick_len,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [DW-1:0] cmd_duty,
  output logic          pwm_oe,
  output logic          pwm_lo,
  output logic          kick_active
);

  localparam int CW  = $clog2(PERIOD);
  localparam int MCW = $clog2(PERIOD + 1);

  logic [CW-1:0]  cnt;
  logic           wrap;
  logic           pend_v;
  logic [DW-1:0]  pend_d;
  logic [DW-1:0]  duty_q;
  logic [DW-1:0]  duty_eff;
  logic [MCW-1:0] run_cmp;
  logic [MCW-1:0] cmp_q;
  logic           drive_active;

  fan_pwm_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .cnt  (cnt),
    .wrap (wrap)
  );

  // One-entry request slot; flushed into the live duty at a boundary.
  assign cmd_ready = !pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_d <= '0;
      duty_q <= '0;
    end else begin
      if (pend_v && (wrap || !en)) begin
        duty_q <= pend_d;
        pend_v <= 1'b0;
      end else if (cmd_valid && cmd_ready) begin
        pend_d <= cmd_duty;
        pend_v <= 1'b1;
      end
    end
  end

  assign duty_eff = pend_v ? pend_d : duty_q;

  fan_pwm_duty_map #(
    .PERIOD (PERIOD),
    .DW     (DW),
    .MIN_PCT(MIN_PCT)
  ) u_map (
    .duty_pct(duty_eff),
    .cmp     (run_cmp)
  );

  fan_pwm_kick_seq #(
    .PERIOD(PERIOD),
    .KW    (KW)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .wrap    (wrap),
    .req_zero(duty_eff == '0),
    .run_cmp (run_cmp),
    .kick_len(kick_len),
    .cmp_q   (cmp_q),
    .kicking (kick_active)
  );

  assign drive_active = (MCW'(cnt) < cmp_q);

  // Open-drain: pulling low when the wanted level is low.
  assign pwm_oe = pol ? drive_active : !drive_active;
  assign pwm_lo = 1'b0;

endmodule

// File: rtl/fan_pwm_kick_chk.sv
module fan_pwm_kick_chk #(
  parameter int PERIOD = 2000,
  parameter int KW     = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pol,
  input logic [KW-1:0] kick_len,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          pwm_oe,
  input logic          kick_active
);

  localparam int CW = $clog2(PERIOD);
  localparam int LW = KW + CW + 2;

  logic [LW-1:0] kick_run;
  logic [LW-1:0] kick_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick_run <= '0;
    end else if (kick_active) begin
      kick_run <= kick_run + LW'(1);
    end else begin
      kick_run <= '0;
    end
  end

  assign kick_limit = LW'(kick_len) * LW'(PERIOD);

  // R2: full active level throughout spin-up
  p_kick_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kick_active |-> (pwm_oe == pol));

  // R2: spin-up never exceeds the programmed number of periods
  p_kick_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kick_run <= kick_limit);

  // R9: spin-up only while enabled
  p_kick_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick_active |-> $past(en));

  // R9: idle level on the clock after disable
  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pwm_oe != pol));

  // R7: slot closes after an acceptance
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

bind fan_pwm_kick fan_pwm_kick_chk #(.PERIOD(PERIOD), .KW(KW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .pol        (pol),
  .kick_len   (kick_len),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .pwm_oe     (pwm_oe),
  .kick_active(kick_active)
);

// File: tb/fan_pwm_kick_test.sv
module fan_pwm_kick_test;

  localparam int CLK_NS = 10;
  localparam int PERIOD = 100;
  localparam int DW     = 7;
  localparam int KW     = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          pol;
  logic [KW-1:0] kick_len;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [DW-1:0] cmd_duty;
  logic          pwm_oe;
  logic          pwm_lo;
  logic          kick_active;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  int    exp_cnt_q[$];
  int    exp_kick_q[$];
  string exp_tag_q[$];

  always #(CLK_NS / 2) clk = !clk;

  fan_pwm_kick #(.PERIOD(PERIOD), .DW(DW), .KW(KW)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .pol        (pol),
    .kick_len   (kick_len),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_duty   (cmd_duty),
    .pwm_oe     (pwm_oe),
    .pwm_lo     (pwm_lo),
    .kick_active(kick_active)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  function automatic int expect_cnt(input int d);
    int c;
    c = d;
    if (c != 0 && c < 20) c = 20;
    if (c > 100) c = 100;
    return c * PERIOD / 100;
  endfunction

  task automatic push(input int cnt, input int kick, input string tag);
    exp_cnt_q.push_back(cnt);
    exp_kick_q.push_back(kick);
    exp_tag_q.push_back(tag);
  endtask

  // One period: push expectation for it, send a request at its start.
  task automatic period_cmd(input int d, input int cur, input int kick, input string tag);
    push(cur, kick, tag);
    cmd_valid = 1'b1;
    cmd_duty  = DW'(d);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (PERIOD - 1) @(negedge clk);
  endtask

  task automatic period_idle(input int cur, input int kick, input string tag);
    push(cur, kick, tag);
    repeat (PERIOD) @(negedge clk);
  endtask

  // Monitor: counts active clocks per period and compares to the scoreboard.
  initial begin
    int  pos  = 0;
    int  acc  = 0;
    bit  k0   = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n || !en) begin
        pos = 0;
        acc = 0;
      end else begin
        if ((pwm_oe ? 1'b0 : 1'b1) == !pol) acc++;
        if (pos == 0) k0 = kick_active;
        pos++;
        if (pos == PERIOD) begin
          if (exp_cnt_q.size() > 0) begin
            int    ec;
            int    ek;
            string et;
            ec = exp_cnt_q.pop_front();
            ek = exp_kick_q.pop_front();
            et = exp_tag_q.pop_front();
            check(acc == ec, {et, " active count"}, acc, ec);
            check(int'(k0) == ek, {et, " kick flag"}, int'(k0), ek);
          end else begin
            check(1'b0, "R1 unexpected period", acc, -1);
          end
          pos = 0;
          acc = 0;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  // Driver
  initial begin
    rst_n     = 1'b0;
    en        = 1'b0;
    pol       = 1'b0;
    kick_len  = KW'(3);
    cmd_valid = 1'b0;
    cmd_duty  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: R8 idle low with pol 0, R7 slot free
    check(pwm_oe == 1'b1, "R8 reset idle oe", int'(pwm_oe), 1);
    check(pwm_lo == 1'b0, "R8 pwm_lo low", int'(pwm_lo), 0);
    check(kick_active == 1'b0, "R2 reset kick flag", int'(kick_active), 0);
    check(cmd_ready == 1'b1, "R7 reset ready", int'(cmd_ready), 1);

    // Request while disabled is absorbed on the next clock (R7)
    cmd_valid = 1'b1;
    cmd_duty  = DW'(50);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R7 ready low after accept", int'(cmd_ready), 0);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R7 ready back while disabled", int'(cmd_ready), 1);

    // Start: R2 spin-up of 3 periods, then request
    en = 1'b1;
    push(PERIOD, 1, "R2 spin-up p1");
    push(PERIOD, 1, "R2 spin-up p2");
    push(PERIOD, 1, "R2 spin-up p3");
    push(expect_cnt(50), 0, "R1 R2 settle 50");
    @(negedge clk);
    repeat (4 * PERIOD) @(negedge clk);

    period_cmd(10,  expect_cnt(50),  0, "R6 old value kept");
    period_cmd(120, expect_cnt(10),  0, "R4 floor 20");
    period_cmd(0,   expect_cnt(120), 0, "R4 ceiling 100");
    period_cmd(30,  0,               0, "R5 stop idle");
    period_idle(PERIOD, 1, "R5 restart spin-up p1");
    period_idle(PERIOD, 1, "R5 restart spin-up p2");
    period_idle(PERIOD, 1, "R5 restart spin-up p3");
    period_idle(expect_cnt(30), 0, "R5 run after restart");

    // Back-pressure: R7
    push(expect_cnt(30), 0, "R7 period of accept");
    cmd_valid = 1'b1;
    cmd_duty  = DW'(60);
    @(negedge clk);
    check(cmd_ready == 1'b0, "R7 slot closed", int'(cmd_ready), 0);
    cmd_duty = DW'(70);
    push(expect_cnt(60), 0, "R7 first request applied");
    repeat (PERIOD) @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R7 held request taken", int'(cmd_ready), 0);
    repeat (PERIOD - 1) @(negedge clk);
    period_idle(expect_cnt(70), 0, "R7 second request applied");

    // Disable: R9
    en = 1'b0;
    @(negedge clk);
    check(pwm_oe == 1'b1, "R9 idle after disable", int'(pwm_oe), 1);
    check(kick_active == 1'b0, "R9 kick flag cleared", int'(kick_active), 0);

    // Inverted polarity and no spin-up: R8, R3
    pol      = 1'b1;
    kick_len = '0;
    @(negedge clk);
    check(pwm_oe == 1'b0, "R8 idle high released", int'(pwm_oe), 0);
    en = 1'b1;
    @(negedge clk);
    period_idle(expect_cnt(70), 0, "R3 no spin-up");
    period_cmd(0, expect_cnt(70), 0, "R8 active-low run");
    push(0, 0, "R8 stop idle high");
    repeat (PERIOD / 2) @(negedge clk);
    check(pwm_oe == 1'b0, "R8 stopped pin released", int'(pwm_oe), 0);
    repeat (PERIOD - PERIOD / 2) @(negedge clk);

    // Re-enable with a fresh spin-up: R9
    en       = 1'b0;
    pol      = 1'b0;
    kick_len = KW'(2);
    cmd_valid = 1'b1;
    cmd_duty  = DW'(25);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    en = 1'b1;
    push(PERIOD, 1, "R9 re-enable spin-up p1");
    push(PERIOD, 1, "R9 re-enable spin-up p2");
    push(expect_cnt(25), 0, "R9 settle 25");
    @(negedge clk);
    repeat (3 * PERIOD) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);

    check(exp_cnt_q.size() == 0, "R1 all periods observed", exp_cnt_q.size(), 0);
    finish_run();
  end

endmodule